// File: doc/BRIEF.md
# Word Program-Verify Sequencer

This block is a host-side controller that fills a range of words in an external parallel flash device and checks each word as it goes. The caller gives a first and a last word address and a start pulse, and supplies the data through a lookup port: the sequencer puts a word address on `src_addr` and expects the word to be written on `src_data`, with no added delay. The sequencer then works through the range one word at a time, driving the device's write strobe, output enable, address and data pins.

For every word it sends a set-up-program command and then the data write. It waits a programming interval, sends a program-verify command, waits a recovery interval, reads the word back and compares it with the source data. A mismatch causes another programming attempt on the same word. A word that still mismatches after the attempt limit ends the whole run as failed. After the last word, or after a failure, the sequencer returns the device to read mode and drops its request for the high programming supply. The supply ramp itself is outside the block: the sequencer raises `vpp_en` and waits until `vpp_ready` is high before it touches the bus.

All intervals are parameters counted in clock cycles. Every bus write has the same shape: address and data are driven before the strobe falls, and data is held one cycle past its rise.

Top module: `wpv_sequencer`

## Requirements
- R1: During and after reset, until the first start, `busy`, `pass`, `fail` and `vpp_en` are low, `fl_we_n` and `fl_oe_n` are high and `fl_dq_oe` is low.
- R2: A start pulse while idle raises `busy` and `vpp_en` on the next clock edge. No write strobe falls until `vpp_ready` is high.
- R3: Each programming attempt writes the set-up-program command 0x0040, then writes the source word (the value on `src_data` while `src_addr` holds that word's address) to the word's address on `fl_addr`.
- R4: The program-verify command 0x00C0 is written after the data write. Between the rise of the data strobe and the fall of the verify strobe there are at least PROG_CYC and at most PROG_CYC+3 clock cycles.
- R5: After the verify command, the word's address is read through `fl_oe_n`. Between the rise of the verify strobe and the fall of `fl_oe_n` there are at least REC_CYC and at most REC_CYC+2 clock cycles. The value read is compared with the source word.
- R6: On a mismatch the same word is programmed again. The attempt count starts at 1 for each word and never passes MAX_PULSES (25 by default). A word that first matches on attempt MAX_PULSES is accepted.
- R7: On a match the sequencer moves to the next higher address and continues through `last_addr` inclusive. When the first and last addresses are equal, exactly one word is programmed.
- R8: After the last word matches, the sequencer writes the read command 0x0000. One cycle after that strobe rises, `busy` and `vpp_en` fall and `pass` rises.
- R9: If attempt MAX_PULSES on a word mismatches, no later address is touched. The sequencer writes 0x0000, then `fail` rises, `fail_addr` holds that word's address, and `busy` and `vpp_en` fall.
- R10: In every bus write, address and data are driven in the cycle before the strobe falls and stay constant while it is low. The strobe stays low for WLOW_CYC cycles, and the data is still driven in the cycle in which the strobe rises. `fl_we_n` and `fl_oe_n` are never low together.
- R11: `pass` and `fail` are never high together. Both are cleared by a start and otherwise keep their value while the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken only while idle) |
| base_addr | input | AW | First word address |
| last_addr | input | AW | Last word address, inclusive |
| src_addr | output | AW | Word address presented to the data source |
| src_data | input | DW | Expected word for `src_addr` |
| vpp_ready | input | 1 | Programming supply has reached its high level |
| vpp_en | output | 1 | Request for the high programming supply |
| fl_addr | output | AW | Device address pins |
| fl_dq_out | output | DW | Data driven to the device |
| fl_dq_oe | output | 1 | Drive enable for `fl_dq_out` |
| fl_dq_in | input | DW | Data returned by the device |
| fl_we_n | output | 1 | Device write strobe, active low |
| fl_oe_n | output | 1 | Device output enable, active low |
| busy | output | 1 | Run in progress |
| pass | output | 1 | Last run programmed every word |
| fail | output | 1 | Last run hit the attempt limit |
| fail_addr | output | AW | Word address at which the run failed |

## Verification
The bench starts a run on one clock edge and expects `busy` and `vpp_en` high at the following falling edge. Each status change at the end of a run is due one cycle after the rising strobe of the closing read command, and the bench's model moves its expected values with the same one-cycle offset. Command and data checks are made at the falling edge in which a strobe edge is first seen. The programming and recovery gaps are measured in clock counts between strobe edges and must lie in the windows R4 and R5 give. A behavioural device model in the bench applies a chosen number of attempts per word before the data takes. This is how runs that pass on the first attempt, on attempt 3, exactly at the limit, and that fail past the limit are all produced.

// File: rtl/wpv_pkg.sv
package wpv_pkg;

  localparam logic [15:0] CMD_READ   = 16'h0000;
  localparam logic [15:0] CMD_SETUP  = 16'h0040;
  localparam logic [15:0] CMD_VERIFY = 16'h00C0;

  typedef enum logic [3:0] {
    S_IDLE, S_RAMP, S_SETUP, S_DATA, S_PWAIT,
    S_VCMD, S_RWAIT, S_READ, S_CHECK, S_RDCMD
  } seq_state_t;

  typedef enum logic [2:0] {
    B_IDLE, B_SET, B_LOW, B_HOLD, B_RD
  } bus_state_t;

  // attempts already spent on the current word have reached the limit
  function automatic bit attempts_spent(int unsigned att, int unsigned lim);
    return att >= lim;
  endfunction

  // the sequencer goes back to a set-up-program write after a readback
  function automatic bit loop_again(bit ok, bit last, bit spent);
    return (ok && !last) || (!ok && !spent);
  endfunction

endpackage

// File: rtl/wpv_wait_timer.sv
module wpv_wait_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         expire
);
  logic [W-1:0] cnt_q;
  logic         act_q;

  // value cycles after the load edge, expire is high for one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load) begin
      cnt_q <= value - W'(1);
      act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - W'(1);
    end
  end

  assign expire = act_q && (cnt_q == '0);
endmodule

// File: rtl/wpv_bus_port.sv
module wpv_bus_port
  import wpv_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int WLOW_CYC = 2,
  parameter int RD_CYC   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          rd,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] pin_addr,
  output logic [DW-1:0] pin_dq_out,
  output logic          pin_dq_oe,
  input  logic [DW-1:0] pin_dq_in,
  output logic          pin_we_n,
  output logic          pin_oe_n
);
  localparam int CMAX = (WLOW_CYC > RD_CYC) ? WLOW_CYC : RD_CYC;
  localparam int CW   = (CMAX > 1) ? $clog2(CMAX) : 1;

  bus_state_t    st_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [DW-1:0] rdata_q;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= B_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
    end else if (req) begin
      addr_q <= addr_i;
      data_q <= data_i;
      st_q   <= rd ? B_RD : B_SET;
      cnt_q  <= rd ? CW'(RD_CYC - 1) : CW'(WLOW_CYC - 1);
    end else begin
      unique case (st_q)
        B_SET:  st_q <= B_LOW;
        B_LOW:  if (cnt_zero) st_q <= B_HOLD;
                else          cnt_q <= cnt_q - CW'(1);
        B_HOLD: st_q <= B_IDLE;
        B_RD:   if (cnt_zero) begin
                  rdata_q <= pin_dq_in;
                  st_q    <= B_IDLE;
                end else begin
                  cnt_q <= cnt_q - CW'(1);
                end
        default: st_q <= B_IDLE;
      endcase
    end
  end

  assign done       = (st_q == B_HOLD) || ((st_q == B_RD) && cnt_zero);
  assign rdata      = rdata_q;
  assign pin_addr   = addr_q;
  assign pin_dq_out = data_q;
  assign pin_dq_oe  = (st_q == B_SET) || (st_q == B_LOW) || (st_q == B_HOLD);
  assign pin_we_n   = (st_q != B_LOW);
  assign pin_oe_n   = (st_q != B_RD);
endmodule

// File: rtl/wpv_sequencer.sv
module wpv_sequencer
  import wpv_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DW         = 16,
  parameter int PROG_CYC   = 20,
  parameter int REC_CYC    = 12,
  parameter int WLOW_CYC   = 2,
  parameter int RD_CYC     = 3,
  parameter int MAX_PULSES = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] last_addr,
  output logic [AW-1:0] src_addr,
  input  logic [DW-1:0] src_data,
  input  logic          vpp_ready,
  output logic          vpp_en,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic          busy,
  output logic          pass,
  output logic          fail,
  output logic [AW-1:0] fail_addr
);
  localparam int ATT_W   = $clog2(MAX_PULSES + 1);
  localparam int TMR_MAX = (PROG_CYC > REC_CYC) ? PROG_CYC : REC_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  seq_state_t     state_q;
  logic [AW-1:0]  cur_addr_q;
  logic [ATT_W-1:0] attempt_q;
  logic           ok_q, busy_q, pass_q, fail_q, vpp_q;
  logic [AW-1:0]  fail_addr_q;

  logic           bus_req, bus_rd, bus_done;
  logic [DW-1:0]  bus_wdata, bus_rdata;
  logic           tmr_load, tmr_exp;
  logic [TMR_W-1:0] tmr_val;

  // named events used by the sequencing and by the bound checker
  logic word_ok, last_word, limit_hit, go_again;
  assign word_ok   = (bus_rdata == src_data);
  assign last_word = (cur_addr_q == last_addr);
  assign limit_hit = attempts_spent(int'(attempt_q), MAX_PULSES);
  assign go_again  = loop_again(word_ok, last_word, limit_hit);

  always_comb begin
    bus_req   = 1'b0;
    bus_rd    = 1'b0;
    bus_wdata = DW'(CMD_READ);
    tmr_load  = 1'b0;
    tmr_val   = TMR_W'(PROG_CYC);
    unique case (state_q)
      S_RAMP:  if (vpp_ready) begin
                 bus_req   = 1'b1;
                 bus_wdata = DW'(CMD_SETUP);
               end
      S_SETUP: if (bus_done) begin
                 bus_req   = 1'b1;
                 bus_wdata = src_data;
               end
      S_DATA:  if (bus_done) begin
                 tmr_load = 1'b1;
                 tmr_val  = TMR_W'(PROG_CYC);
               end
      S_PWAIT: if (tmr_exp) begin
                 bus_req   = 1'b1;
                 bus_wdata = DW'(CMD_VERIFY);
               end
      S_VCMD:  if (bus_done) begin
                 tmr_load = 1'b1;
                 tmr_val  = TMR_W'(REC_CYC);
               end
      S_RWAIT: if (tmr_exp) begin
                 bus_req = 1'b1;
                 bus_rd  = 1'b1;
               end
      S_CHECK: begin
                 bus_req   = 1'b1;
                 bus_wdata = go_again ? DW'(CMD_SETUP) : DW'(CMD_READ);
               end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      cur_addr_q  <= '0;
      attempt_q   <= '0;
      ok_q        <= 1'b0;
      busy_q      <= 1'b0;
      pass_q      <= 1'b0;
      fail_q      <= 1'b0;
      vpp_q       <= 1'b0;
      fail_addr_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE:  if (start) begin
                   state_q    <= S_RAMP;
                   vpp_q      <= 1'b1;
                   busy_q     <= 1'b1;
                   pass_q     <= 1'b0;
                   fail_q     <= 1'b0;
                   cur_addr_q <= base_addr;
                   attempt_q  <= ATT_W'(1);
                 end
        S_RAMP:  if (vpp_ready) state_q <= S_SETUP;
        S_SETUP: if (bus_done)  state_q <= S_DATA;
        S_DATA:  if (bus_done)  state_q <= S_PWAIT;
        S_PWAIT: if (tmr_exp)   state_q <= S_VCMD;
        S_VCMD:  if (bus_done)  state_q <= S_RWAIT;
        S_RWAIT: if (tmr_exp)   state_q <= S_READ;
        S_READ:  if (bus_done)  state_q <= S_CHECK;
        S_CHECK: begin
                   if (go_again) begin
                     state_q <= S_SETUP;
                     if (word_ok) begin
                       cur_addr_q <= cur_addr_q + AW'(1);
                       attempt_q  <= ATT_W'(1);
                     end else begin
                       attempt_q  <= attempt_q + ATT_W'(1);
                     end
                   end else begin
                     state_q <= S_RDCMD;
                     ok_q    <= word_ok;
                     if (!word_ok) fail_addr_q <= cur_addr_q;
                   end
                 end
        S_RDCMD: if (bus_done) begin
                   state_q <= S_IDLE;
                   vpp_q   <= 1'b0;
                   busy_q  <= 1'b0;
                   pass_q  <= ok_q;
                   fail_q  <= !ok_q;
                 end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  wpv_wait_timer #(.W(TMR_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .value  (tmr_val),
    .expire (tmr_exp)
  );

  wpv_bus_port #(
    .AW(AW), .DW(DW), .WLOW_CYC(WLOW_CYC), .RD_CYC(RD_CYC)
  ) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (bus_req),
    .rd         (bus_rd),
    .addr_i     (cur_addr_q),
    .data_i     (bus_wdata),
    .done       (bus_done),
    .rdata      (bus_rdata),
    .pin_addr   (fl_addr),
    .pin_dq_out (fl_dq_out),
    .pin_dq_oe  (fl_dq_oe),
    .pin_dq_in  (fl_dq_in),
    .pin_we_n   (fl_we_n),
    .pin_oe_n   (fl_oe_n)
  );

  assign src_addr  = cur_addr_q;
  assign vpp_en    = vpp_q;
  assign busy      = busy_q;
  assign pass      = pass_q;
  assign fail      = fail_q;
  assign fail_addr = fail_addr_q;
endmodule

// File: rtl/wpv_sequencer_chk.sv
module wpv_sequencer_chk #(
  parameter int MAX_PULSES = 25,
  parameter int ATT_W      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             we_n,
  input logic             oe_n,
  input logic             dq_oe,
  input logic             vpp_en,
  input logic             vpp_ready,
  input logic             busy,
  input logic             pass,
  input logic             fail,
  input logic [ATT_W-1:0] attempt
);
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));

  // R10
  drive_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe);

  // R2
  supply_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> (vpp_en && vpp_ready));

  // R6
  attempt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (attempt >= ATT_W'(1) && attempt <= ATT_W'(MAX_PULSES)));

  // R11
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  // R8
  end_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ((pass || fail) && !vpp_en));

  // R11
  idle_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> ($stable(pass) && $stable(fail)));
endmodule

bind wpv_sequencer wpv_sequencer_chk #(
  .MAX_PULSES(MAX_PULSES), .ATT_W(ATT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .we_n      (fl_we_n),
  .oe_n      (fl_oe_n),
  .dq_oe     (fl_dq_oe),
  .vpp_en    (vpp_en),
  .vpp_ready (vpp_ready),
  .busy      (busy),
  .pass      (pass),
  .fail      (fail),
  .attempt   (attempt_q)
);

// File: tb/wpv_sequencer_test.sv
module wpv_sequencer_test;
  localparam int AW = 8, DW = 16;
  localparam int PROG = 20, REC = 12, WLOW = 2, RDC = 3, LIMIT = 25;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, vpp_ready = 1'b0;
  logic [AW-1:0] base_addr = '0, last_addr = '0;
  logic [AW-1:0] src_addr, fl_addr, fail_addr;
  logic [DW-1:0] src_data, fl_dq_out, fl_dq_in;
  logic fl_dq_oe, fl_we_n, fl_oe_n, vpp_en, busy, pass, fail;

  always #5 clk = ~clk;

  wpv_sequencer #(.AW(AW), .DW(DW), .PROG_CYC(PROG), .REC_CYC(REC),
    .WLOW_CYC(WLOW), .RD_CYC(RDC), .MAX_PULSES(LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .last_addr(last_addr), .src_addr(src_addr), .src_data(src_data),
    .vpp_ready(vpp_ready), .vpp_en(vpp_en), .fl_addr(fl_addr),
    .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .busy(busy), .pass(pass),
    .fail(fail), .fail_addr(fail_addr));

  function automatic logic [DW-1:0] word_of(logic [AW-1:0] a);
    return {a, ~a} ^ 16'h5A3C;
  endfunction
  assign src_data = word_of(src_addr);

  int n_chk = 0, n_bad = 0;
  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural device: words take only after need[a] programming writes
  logic [DW-1:0] mem [0:255];
  int need [0:255];
  int tries [0:255];
  int mode = 0; // 0 read, 1 after set-up-program
  assign fl_dq_in = mem[fl_addr];

  // expected bus traffic
  int exp_wa[$]; int exp_wd[$]; bit exp_wm[$]; int exp_ra[$];
  bit busy_exp = 0, arm_set = 0, arm_clr = 0;
  longint cyc = 0, t_data_rise = 0, t_vfy_rise = 0;
  logic prev_we = 1'b1, prev_oe = 1'b1, prev_dqoe = 1'b0;
  logic [AW-1:0] prev_addr = '0, lat_addr = '0;
  logic [DW-1:0] low_data = '0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (arm_set) begin busy_exp = 1; arm_set = 0; end
      if (arm_clr) begin busy_exp = 0; arm_clr = 0; end
      // R2 R8: per-clock comparison against the model
      chk(busy == busy_exp, "R2/R8 busy", busy, busy_exp);
      chk(vpp_en == busy_exp, "R2/R8 vpp_en", vpp_en, busy_exp);
      chk(!(pass && fail), "R11 pass/fail exclusive", {pass, fail}, 0);
      chk(!(!fl_we_n && !fl_oe_n), "R10 strobes exclusive", {fl_we_n, fl_oe_n}, 3);
      if (start && !busy_exp) arm_set = 1;
      if (prev_we && !fl_we_n) begin
        lat_addr = fl_addr;
        chk(prev_dqoe && prev_addr == fl_addr, "R10 setup before fall", prev_addr, fl_addr);
        chk(vpp_en && vpp_ready, "R2 supply before strobe", {vpp_en, vpp_ready}, 3);
        if (fl_dq_out == 16'h00C0 && mode == 0) begin
          chk(cyc - t_data_rise >= PROG && cyc - t_data_rise <= PROG + 3,
              "R4 program wait", cyc - t_data_rise, PROG);
        end
      end
      if (!fl_we_n) begin
        chk(fl_addr == lat_addr && fl_dq_oe, "R10 stable while low", fl_addr, lat_addr);
        low_data = fl_dq_out;
      end
      if (!prev_we && fl_we_n) begin
        chk(fl_dq_oe && fl_dq_out == low_data, "R10 data hold", fl_dq_out, low_data);
        if (exp_wd.size() == 0) chk(0, "R3 unexpected write", fl_dq_out, 0);
        else begin
          int ea, ed; bit em;
          ea = exp_wa.pop_front(); ed = exp_wd.pop_front(); em = exp_wm.pop_front();
          chk(fl_dq_out == DW'(ed), "R3/R4/R8 write data", fl_dq_out, ed);
          if (em) chk(lat_addr == AW'(ea), "R3 write address", lat_addr, ea);
        end
        if (mode == 1) begin
          tries[lat_addr]++;
          mem[lat_addr] = (tries[lat_addr] >= need[lat_addr]) ? fl_dq_out : (fl_dq_out ^ 16'h0100);
          mode = 0;
          t_data_rise = cyc;
        end else if (fl_dq_out == 16'h0040) mode = 1;
        else if (fl_dq_out == 16'h00C0) t_vfy_rise = cyc;
        else if (fl_dq_out == 16'h0000 && busy_exp) arm_clr = 1;
      end
      if (prev_oe && !fl_oe_n) begin
        chk(cyc - t_vfy_rise >= REC && cyc - t_vfy_rise <= REC + 2,
            "R5 recovery wait", cyc - t_vfy_rise, REC);
        if (exp_ra.size() == 0) chk(0, "R5 unexpected read", fl_addr, 0);
        else begin
          int ra;
          ra = exp_ra.pop_front();
          chk(fl_addr == AW'(ra), "R5 read address", fl_addr, ra);
        end
      end
    end
    prev_we = fl_we_n; prev_oe = fl_oe_n; prev_dqoe = fl_dq_oe; prev_addr = fl_addr;
  end

  task automatic expect_run(int b, int l);
    for (int a = b; a <= l; a++) begin
      int n;
      n = (need[a] > LIMIT) ? LIMIT : need[a];
      for (int k = 0; k < n; k++) begin
        exp_wa.push_back(0); exp_wd.push_back(16'h0040); exp_wm.push_back(0);
        exp_wa.push_back(a); exp_wd.push_back(int'(word_of(AW'(a)))); exp_wm.push_back(1);
        exp_wa.push_back(0); exp_wd.push_back(16'h00C0); exp_wm.push_back(0);
        exp_ra.push_back(a);
      end
      if (need[a] > LIMIT) break;
    end
    exp_wa.push_back(0); exp_wd.push_back(16'h0000); exp_wm.push_back(0);
  endtask

  task automatic run(int b, int l, bit exp_pass, int exp_fa, string tag);
    expect_run(b, l);
    @(posedge clk); #2;
    base_addr = AW'(b); last_addr = AW'(l); start = 1'b1;
    @(posedge clk); #2; start = 1'b0;
    @(negedge clk);
    chk(!pass && !fail, {"R11 cleared by start ", tag}, {pass, fail}, 0);
    repeat (6) @(negedge clk);
    chk(fl_we_n && fl_oe_n, {"R2 bus quiet before supply ", tag}, {fl_we_n, fl_oe_n}, 3);
    @(posedge clk); #2; vpp_ready = 1'b1;
    for (int i = 0; i < 40000 && busy; i++) @(negedge clk);
    @(negedge clk);
    chk(!busy && !vpp_en, {"R8 idle at end ", tag}, {busy, vpp_en}, 0);
    chk(pass == exp_pass && fail == !exp_pass, {"R8/R9 status ", tag}, {pass, fail}, {exp_pass, !exp_pass});
    if (!exp_pass) chk(fail_addr == AW'(exp_fa), {"R9 fail address ", tag}, fail_addr, exp_fa);
    chk(exp_wd.size() == 0 && exp_ra.size() == 0, {"R6/R7 all traffic seen ", tag},
        exp_wd.size() + exp_ra.size(), 0);
    exp_wa.delete(); exp_wd.delete(); exp_wm.delete(); exp_ra.delete();
    @(posedge clk); #2; vpp_ready = 1'b0;
    repeat (5) @(negedge clk);
    chk(pass == exp_pass && fail == !exp_pass, {"R11 status held ", tag}, {pass, fail}, {exp_pass, !exp_pass});
  endtask

  initial begin
    for (int a = 0; a < 256; a++) begin mem[a] = 16'hFFFF; need[a] = 1; tries[a] = 0; end
    need[1] = LIMIT; need[2] = 3; need[11] = 99; need[20] = 2;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !pass && !fail && !vpp_en, "R1 status in reset", {busy, pass, fail, vpp_en}, 0);
    chk(fl_we_n && fl_oe_n && !fl_dq_oe, "R1 bus in reset", {fl_we_n, fl_oe_n, fl_dq_oe}, 6);
    @(posedge clk); #2; rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !vpp_en && fl_we_n && fl_oe_n, "R1 idle after reset", {busy, vpp_en, fl_we_n, fl_oe_n}, 3);
    run(4, 9, 1, 0, "first-attempt words");           // R3 R7 R8
    run(0, 3, 1, 0, "retry and limit-exact word");    // R6
    run(10, 12, 0, 11, "word past limit");            // R9
    run(20, 20, 1, 0, "single word range");           // R7
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule